// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block holds the return addresses of a small processor core. The PC logic raises a push strobe with the current program counter on a subroutine call or an interrupt acknowledge. It raises a pop strobe on a return or a return-from-interrupt. One cycle after a pop, the registered return-address output carries the address to resume from. Software has no path to the entries or to the pointer.

The stack has four levels. A call made while all four are occupied overwrites the oldest entry, so the four newest return addresses survive. The full flag goes to the interrupt controller, which holds off acknowledging a pending request while the flag is high. A return frees a level, the flag falls, and the interrupt can then be taken.

Top module: `rs_ret_stack`

## Requirements
- R1: While reset is high at a clock edge, the stack becomes empty: full_o reads 0 and ret_addr_o reads 0 after that edge.
- R2: A pop (pop_i=1, push_i=0) places the most recently pushed address that is still held on ret_addr_o. The value appears after the clock edge that samples the pop, so entries come back in last-in first-out order.
- R3: full_o is 1 exactly when four entries are held, and 0 with zero to three entries.
- R4: A push while four entries are held discards the oldest entry. The four most recent addresses are kept, and full_o stays 1.
- R5: A pop while the stack is empty puts the most recently popped address on ret_addr_o again and leaves the stack empty. A later push followed by a pop returns the newly pushed address.
- R6: When push_i and pop_i are both 1 in the same cycle, only the push takes effect. ret_addr_o keeps its value, and the pushed address is the next one popped.
- R7: In a cycle with no pop, ret_addr_o keeps its previous value.
- R8: A pop from a full stack clears full_o after the clock edge that samples the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Save pc_i (call or interrupt acknowledge) |
| pop_i | input | 1 | Restore an address (return or return-from-interrupt) |
| pc_i | input | PC_W (10) | Address to save |
| ret_addr_o | output | PC_W (10) | Registered restored address |
| full_o | output | 1 | All levels occupied |

## Verification
The bench pushes a fifth address onto a full stack. A design that dropped the new address, or lost the wrong entry, would return a stale address during the four pops that follow. It pops past empty twice and then pushes again. A pointer that wrapped below zero would return garbage on the empty pops and a misplaced entry afterwards. It also raises both strobes together, and holds the strobes idle after a pop. A design that acted on both strobes, or let the output register drift, would change ret_addr_o when it should hold. Throughout, full_o is compared with the model's occupancy, which exposes an off-by-one full threshold or a flag that does not fall after a return.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } rs_op_e;
endpackage

// File: rtl/rs_store.sv
module rs_store #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  // Array without reset so it can map to distributed or block RAM.
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl #(
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  rs_pkg::rs_op_e op,
  output logic [CW-1:0]  count_o,
  output logic [AW-1:0]  wptr_o,
  output logic [AW-1:0]  raddr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [AW-1:0] wptr_q, wptr_inc, wptr_dec;
  logic [CW-1:0] cnt_q;

  assign wptr_inc = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
  assign wptr_dec = (wptr_q == '0) ? LAST : wptr_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (op)
        rs_pkg::OP_PUSH: begin
          wptr_q <= wptr_inc;
          if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        end
        rs_pkg::OP_POP: begin
          if (cnt_q != '0) begin
            wptr_q <= wptr_dec;
            cnt_q  <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // On an empty stack the write pointer rests on the last vacated slot.
  assign raddr_o = (cnt_q == '0) ? wptr_q : wptr_dec;
  assign count_o = cnt_q;
  assign wptr_o  = wptr_q;
endmodule

// File: rtl/rs_ret_stack.sv
module rs_ret_stack #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] ret_addr_o,
  output logic            full_o
);
  rs_pkg::rs_op_e op;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  wptr, raddr;

  always_comb begin
    if (push_i)     op = rs_pkg::OP_PUSH;
    else if (pop_i) op = rs_pkg::OP_POP;
    else            op = rs_pkg::OP_IDLE;
  end

  rs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .op(op),
    .count_o(cnt), .wptr_o(wptr), .raddr_o(raddr)
  );

  rs_store #(.W(PC_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .we(op == rs_pkg::OP_PUSH), .waddr(wptr), .wdata(pc_i),
    .re(op == rs_pkg::OP_POP), .raddr(raddr), .rdata(ret_addr_o)
  );

  assign full_o = (cnt == CW'(DEPTH));
endmodule

// File: rtl/rs_ret_stack_chk.sv
module rs_ret_stack_chk #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CW    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            push_i,
  input logic            pop_i,
  input logic [PC_W-1:0] ret_addr_o,
  input logic            full_o,
  input logic [CW-1:0]   cnt,
  input logic [AW-1:0]   wptr
);
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (!full_o && ret_addr_o == '0 && cnt == '0));

  p_full_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i) |=> full_o);

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (push_i && !full_o) |=> (cnt == $past(cnt) + 1'b1));

  p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && cnt == '0) |=> (cnt == '0 && $stable(wptr)));

  p_both_push_r6: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> $stable(ret_addr_o));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !pop_i |=> $stable(ret_addr_o));

  p_pop_frees_r8: assert property (@(posedge clk) disable iff (rst)
    (full_o && pop_i && !push_i) |=> !full_o);
endmodule

bind rs_ret_stack rs_ret_stack_chk #(
  .PC_W(PC_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)
) chk_i (
  .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
  .ret_addr_o(ret_addr_o), .full_o(full_o), .cnt(cnt), .wptr(wptr)
);

// File: tb/rs_ret_stack_tb.sv
module rs_ret_stack_tb_top;
  localparam int PC_W  = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push = 1'b0, pop = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic [PC_W-1:0] ret;
  logic full;

  int n_vec = 0, n_err = 0;
  int model[$];
  int exp_q[$];
  string tag_q[$];
  int last_pop = 0;
  logic pend = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rs_ret_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .push_i(push), .pop_i(pop),
    .pc_i(pc), .ret_addr_o(ret), .full_o(full)
  );

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_push(int v);
    @(negedge clk);
    push = 1'b1; pop = 1'b0; pc = PC_W'(v);
    model.push_back(v);
    if (model.size() > DEPTH) void'(model.pop_front());
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic do_pop(string req);
    int e;
    @(negedge clk);
    pop = 1'b1; push = 1'b0;
    if (model.size() > 0) begin
      e = model.pop_back();
      last_pop = e;
    end else e = last_pop;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic do_both(int v);
    @(negedge clk);
    push = 1'b1; pop = 1'b1; pc = PC_W'(v);
    model.push_back(v);
    if (model.size() > DEPTH) void'(model.pop_front());
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic chk_full(string req);
    chk(req, int'(full), int'(model.size() == DEPTH));
  endtask

  // Monitor: compares each effective pop's result with the scoreboard.
  always @(posedge clk) pend <= pop && !push && !rst;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk("R2 scoreboard underrun", 1, 0);
      else chk(tag_q.pop_front(), int'(ret), exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int hold;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 full after reset", int'(full), 0);
    chk("R1 ret after reset", int'(ret), 0);

    do_push(100); chk_full("R3 one entry");
    do_push(200);
    do_push(300); chk_full("R3 three entries");
    do_push(400); chk_full("R3 four entries");
    do_pop("R2 lifo top");
    chk_full("R8 pop frees a level");
    do_push(500); chk_full("R3 refilled");
    do_push(600); chk_full("R4 overflow keeps full");
    do_pop("R4 newest after overflow");
    do_pop("R4 second");
    do_pop("R4 third");
    do_pop("R4 oldest kept, 100 lost");
    chk_full("R3 empty");
    do_pop("R5 empty pop repeats last");
    do_pop("R5 empty pop again");
    do_push(700);
    do_pop("R5 push after empty pops");

    hold = int'(ret);
    repeat (3) @(negedge clk);
    chk("R7 hold while idle", int'(ret), hold);

    do_both(800);
    chk("R6 output held on both strobes", int'(ret), hold);
    do_pop("R6 push won");

    for (int i = 1; i <= 10; i++) do_push(i * 37);
    chk_full("R4 full after long burst");
    for (int i = 0; i < 5; i++) do_pop("R2 burst drain");
    chk_full("R3 drained");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("R2 results missing", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule